// File: doc/BRIEF.md
# 64-bit Prescaled Alarm Timer

This block is a general-purpose 64-bit counter with a small word-addressed register port. A selectable tick source passes through a programmable prescaler. Each prescaler output step moves the counter up or down by one. A 64-bit comparator raises an alarm when the count equals a programmed value. The alarm can reload the counter from a 64-bit reload register. Software can also force that reload at any time.

Software never reads the live counter. It writes a request bit, which reads back 1 while the request is pending. One cycle later the count is frozen into two 32-bit snapshot words and the request bit clears. The alarm sets a raw interrupt flag. A mask register gates the flag onto the interrupt pin, and a write-one-to-clear register acknowledges it.

Registers are addressed by word. All writes take effect on the next clock edge. Reads are combinational from the address.

Top module: `alarm_timer64`

## Requirements
- R1: After reset, every readable register returns 0, the counter is 0, and `irq_o` is low.
- R2: The control word (address 0) holds the divide ratio in bits [16 +: DIV_W]. A field value N of 2 or more gives one counter step per N selected ticks while running. A value of 0 gives one step per 2^DIV_W ticks. If a shrunken ratio leaves the phase at or beyond the new limit, the next tick steps the counter.
- R3: Writing the control word with bit 5 set returns the prescaler phase to zero on that edge. Bit 5 always reads 0.
- R4: Control bit 0 enables counting, and while it is 0 the count holds. Control bit 1 selects the direction: 1 counts up, 0 counts down. The count wraps modulo 2^64 in both directions.
- R5: Control bit 4 selects the tick source, `src_tick_i[1]` when 1 and `src_tick_i[0]` when 0. Ticks on the other input have no effect.
- R6: Writing 1 to bit 0 of address 1 makes address 1 read 1 for exactly one cycle. At the following edge, addresses 2 (low word) and 3 (high word) capture the count present during that cycle, and address 1 returns to 0.
- R7: The alarm value is written at addresses 4 (low word) and 5 (high word). While control bit 3 (alarm enable) is 1 and the count equals the alarm value, the next edge sets raw status bit 0 (address 10) and clears alarm enable.
- R8: If control bit 2 (auto-reload) is set when the alarm fires, the next edge loads the counter with the reload value (addresses 6 low and 7 high) instead of stepping.
- R9: Writing 1 to bit 0 of address 8 loads the reload value into the counter on that edge. This takes priority over the alarm and the prescaler.
- R10: The raw status sets on an alarm even while masked. `irq_o` equals raw bit 0 AND enable bit 0 (address 9). Writing 1 to bit 0 of address 11 clears raw bit 0, but an alarm in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick_i | input | 2 | Tick strobes of the two selectable timer sources |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wr_data_i | input | REG_W | Write data |
| rd_data_o | output | REG_W | Read data for `addr_i` |
| irq_o | output | 1 | Masked alarm interrupt |

## Verification
The bench builds the block with REG_W of 32 and DIV_W narrowed to 4. With DIV_W at 4, the zero-encoded maximum ratio is only 16 ticks, so steps at that ratio, ratio changes and phase resets all occur within a few hundred cycles. The full 64-bit counter is kept, and its wrap in both directions is reached by loading reload values next to the boundaries. Alarm and auto-reload are driven from values chosen relative to the modelled count. The interrupt mask is toggled around a pending flag.

// File: rtl/tmr_pkg.sv
// Package: register addresses, control bit positions and the control struct
// shared by the alarm timer modules. Assumes word addressing with 4 bits.
package tmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_UPD     = 4'd1;
    localparam logic [ADDR_W-1:0] A_SNAP_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_SNAP_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_ALM_LO  = 4'd4;
    localparam logic [ADDR_W-1:0] A_ALM_HI  = 4'd5;
    localparam logic [ADDR_W-1:0] A_RLD_LO  = 4'd6;
    localparam logic [ADDR_W-1:0] A_RLD_HI  = 4'd7;
    localparam logic [ADDR_W-1:0] A_LOAD    = 4'd8;
    localparam logic [ADDR_W-1:0] A_IEN     = 4'd9;
    localparam logic [ADDR_W-1:0] A_IRAW    = 4'd10;
    localparam logic [ADDR_W-1:0] A_ICLR    = 4'd11;

    localparam int B_RUN  = 0;
    localparam int B_UP   = 1;
    localparam int B_AR   = 2;
    localparam int B_AEN  = 3;
    localparam int B_SEL  = 4;
    localparam int B_DRST = 5;
    localparam int B_DIV  = 16;

    typedef struct packed {
        logic clk_sel;
        logic alarm_en;
        logic autoreload;
        logic count_up;
        logic run;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: counts selected ticks while running and emits one step per
// ratio ticks. A field value of 0 means ratio 2^DIV_W. Assumes the tick input
// is a one-cycle-per-event strobe synchronous to clk.
module tmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             clr_i,
    output logic             step_o
);
    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] limit;
    logic             adv;

    // Terminal phase value: ratio minus one, with 0 wrapping to all ones.
    always_comb begin
        limit = div_i - DIV_W'(1);
    end

    assign adv    = run_i && tick_i;
    assign step_o = adv && (phase >= limit);

    // Phase counter: cleared on request, otherwise advanced by each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr_i) begin
            phase <= '0;
        end else if (adv) begin
            phase <= step_o ? '0 : phase + DIV_W'(1);
        end
    end

    assert_divclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (phase == '0));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(phase));
endmodule

// File: rtl/tmr_core.sv
// Counter core: the 64-bit count with load, auto-reload and up/down step,
// plus the alarm comparator. Assumes the step input comes from the prescaler.
module tmr_core #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             up_i,
    input  logic             arm_i,
    input  logic             autoreload_i,
    input  logic             sw_load_i,
    input  logic [CNT_W-1:0] alarm_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] count;

    assign hit_o   = arm_i && (count == alarm_i);
    assign count_o = count;

    // Count register: software load, then alarm reload, then a prescaled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (sw_load_i) begin
            count <= reload_i;
        end else if (hit_o && autoreload_i) begin
            count <= reload_i;
        end else if (step_i) begin
            count <= up_i ? count + CNT_W'(1) : count - CNT_W'(1);
        end
    end

    assert_swload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_load_i |=> (count == $past(reload_i)));

    assert_autoreload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && autoreload_i && !sw_load_i) |=> (count == $past(reload_i)));

    assert_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && up_i && !sw_load_i && !(hit_o && autoreload_i))
        |=> (count == $past(count) + CNT_W'(1)));

    assert_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !up_i && !sw_load_i && !(hit_o && autoreload_i))
        |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/tmr_regs.sv
// Register file: control, alarm and reload words, the snapshot handshake and
// the interrupt flag. Assumes CNT_W equals two register words.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int DIV_W = 16,
    parameter int CNT_W = 2 * REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              hit_i,
    output tmr_ctrl_t         ctrl_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              divclr_o,
    output logic              sw_load_o,
    output logic [CNT_W-1:0]  alarm_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam int NWORDS = CNT_W / REG_W;

    tmr_ctrl_t        ctrl;
    logic [DIV_W-1:0] div;
    logic [CNT_W-1:0] alarm;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] snap;
    logic             pend;
    logic             ien;
    logic             raw;
    logic             wr_ctrl, wr_upd, wr_iclr;

    assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
    assign wr_upd    = wr_en_i && (addr_i == A_UPD) && wr_data_i[0];
    assign wr_iclr   = wr_en_i && (addr_i == A_ICLR) && wr_data_i[0];
    assign divclr_o  = wr_ctrl && wr_data_i[B_DRST];
    assign sw_load_o = wr_en_i && (addr_i == A_LOAD) && wr_data_i[0];
    assign ctrl_o    = ctrl;
    assign div_o     = div;
    assign alarm_o   = alarm;
    assign reload_o  = reload;
    assign irq_o     = raw && ien;

    // Control word: software writes; a firing alarm disarms itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            div  <= '0;
        end else if (wr_ctrl) begin
            ctrl.run        <= wr_data_i[B_RUN];
            ctrl.count_up   <= wr_data_i[B_UP];
            ctrl.autoreload <= wr_data_i[B_AR];
            ctrl.alarm_en   <= wr_data_i[B_AEN];
            ctrl.clk_sel    <= wr_data_i[B_SEL];
            div             <= wr_data_i[B_DIV +: DIV_W];
        end else if (hit_i) begin
            ctrl.alarm_en   <= 1'b0;
        end
    end

    // Alarm and reload words, one register word each per generated slice.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                alarm[w*REG_W +: REG_W]  <= '0;
                reload[w*REG_W +: REG_W] <= '0;
            end else if (wr_en_i) begin
                if (addr_i == A_ALM_LO + ADDR_W'(w))
                    alarm[w*REG_W +: REG_W] <= wr_data_i;
                if (addr_i == A_RLD_LO + ADDR_W'(w))
                    reload[w*REG_W +: REG_W] <= wr_data_i;
            end
        end
    end

    // Snapshot handshake: request pends one cycle, then the count is frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            snap <= '0;
        end else begin
            if (pend)
                snap <= count_i;
            pend <= wr_upd;
        end
    end

    // Interrupt mask and raw flag; a new alarm outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 1'b0;
            raw <= 1'b0;
        end else begin
            if (wr_en_i && (addr_i == A_IEN))
                ien <= wr_data_i[0];
            raw <= hit_i || (raw && !wr_iclr);
        end
    end

    // Read multiplexer over the word map.
    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            A_CTRL: begin
                rd_data_o[B_RUN]            = ctrl.run;
                rd_data_o[B_UP]             = ctrl.count_up;
                rd_data_o[B_AR]             = ctrl.autoreload;
                rd_data_o[B_AEN]            = ctrl.alarm_en;
                rd_data_o[B_SEL]            = ctrl.clk_sel;
                rd_data_o[B_DIV +: DIV_W]   = div;
            end
            A_UPD:     rd_data_o[0] = pend;
            A_SNAP_LO: rd_data_o    = snap[0 +: REG_W];
            A_SNAP_HI: rd_data_o    = snap[REG_W +: REG_W];
            A_ALM_LO:  rd_data_o    = alarm[0 +: REG_W];
            A_ALM_HI:  rd_data_o    = alarm[REG_W +: REG_W];
            A_RLD_LO:  rd_data_o    = reload[0 +: REG_W];
            A_RLD_HI:  rd_data_o    = reload[REG_W +: REG_W];
            A_IEN:     rd_data_o[0] = ien;
            A_IRAW:    rd_data_o[0] = raw;
            default:   rd_data_o    = '0;
        endcase
    end

    assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !wr_ctrl) |=> !ctrl.alarm_en);

    assert_updclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !wr_upd) |=> !pend);

    assert_snap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> (snap == $past(count_i)));

    assert_rawset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> raw);

    assert_rawclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_iclr && !hit_i) |=> !raw);
endmodule

// File: rtl/alarm_timer64.sv
// Top: 64-bit prescaled alarm timer. Selects one of two tick strobes, runs it
// through the prescaler into the counter core, and exposes everything through
// the register file. Assumes both tick strobes are synchronous to clk.
module alarm_timer64
    import tmr_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o
);
    localparam int CNT_W = 2 * REG_W;

    tmr_ctrl_t        ctrl;
    logic [DIV_W-1:0] div;
    logic             divclr, sw_load, sel_tick, step, hit;
    logic [CNT_W-1:0] alarm, reload, count;

    // Tick source selection.
    assign sel_tick = ctrl.clk_sel ? src_tick_i[1] : src_tick_i[0];

    tmr_regs #(.REG_W(REG_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .count_i   (count),
        .hit_i     (hit),
        .ctrl_o    (ctrl),
        .div_o     (div),
        .divclr_o  (divclr),
        .sw_load_o (sw_load),
        .alarm_o   (alarm),
        .reload_o  (reload),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (sel_tick),
        .run_i  (ctrl.run),
        .div_i  (div),
        .clr_i  (divclr),
        .step_o (step)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .up_i         (ctrl.count_up),
        .arm_i        (ctrl.alarm_en),
        .autoreload_i (ctrl.autoreload),
        .sw_load_i    (sw_load),
        .alarm_i      (alarm),
        .reload_i     (reload),
        .count_o      (count),
        .hit_o        (hit)
    );

    assert_srcsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_tick_i[ctrl.clk_sel]) |-> !step);
endmodule

// File: tb/alarm_timer64_bench.sv
module alarm_timer64_bench;
    localparam int REG_W = 32;
    localparam int DIV_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       src_tick = 2'b00;
    logic             wr_en = 1'b0;
    logic [3:0]       addr = 4'd0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    rate0 = 0;
    int    rate1 = 0;

    // Reference state
    longint unsigned m_cnt, m_alarm, m_reload, m_snap;
    bit m_run, m_up, m_ar, m_aen, m_sel, m_pend, m_ien, m_raw;
    int m_div, m_pc;

    always #4 clk = ~clk;

    alarm_timer64 #(.REG_W(REG_W), .DIV_W(DIV_W)) u_alarm_timer64 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick_i (src_tick),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wr_data_i  (wr_data),
        .rd_data_o  (rd_data),
        .irq_o      (irq)
    );

    task automatic model_reset();
        m_cnt = 0; m_alarm = 0; m_reload = 0; m_snap = 0;
        m_run = 0; m_up = 0; m_ar = 0; m_aen = 0; m_sel = 0;
        m_pend = 0; m_ien = 0; m_raw = 0; m_div = 0; m_pc = 0;
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            4'd0: r = (32'(m_div) << 16) | (32'(m_sel) << 4) | (32'(m_aen) << 3)
                      | (32'(m_ar) << 2) | (32'(m_up) << 1) | 32'(m_run);
            4'd1: r = 32'(m_pend);
            4'd2: r = m_snap[31:0];
            4'd3: r = m_snap[63:32];
            4'd4: r = m_alarm[31:0];
            4'd5: r = m_alarm[63:32];
            4'd6: r = m_reload[31:0];
            4'd7: r = m_reload[63:32];
            4'd9: r = 32'(m_ien);
            4'd10: r = 32'(m_raw);
            default: r = '0;
        endcase
        return r;
    endfunction

    // One clock edge of the behavioural reference.
    task automatic model_step();
        bit hit, tk, stp, w;
        int lim;
        longint unsigned ncnt;
        hit = m_aen && (m_cnt == m_alarm);
        lim = (m_div == 0) ? (1 << DIV_W) - 1 : m_div - 1;
        tk  = m_run && src_tick[m_sel];
        stp = tk && (m_pc >= lim);
        w   = wr_en;
        ncnt = m_cnt;
        if (w && addr == 4'd8 && wr_data[0]) ncnt = m_reload;
        else if (hit && m_ar) ncnt = m_reload;
        else if (stp) ncnt = m_up ? m_cnt + 64'd1 : m_cnt - 64'd1;
        if (w && addr == 4'd0 && wr_data[5]) m_pc = 0;
        else if (tk) m_pc = stp ? 0 : m_pc + 1;
        if (m_pend) m_snap = m_cnt;
        m_pend = w && addr == 4'd1 && wr_data[0];
        m_raw = hit || (m_raw && !(w && addr == 4'd11 && wr_data[0]));
        if (w && addr == 4'd9) m_ien = wr_data[0];
        if (w && addr == 4'd4) m_alarm[31:0] = wr_data;
        if (w && addr == 4'd5) m_alarm[63:32] = wr_data;
        if (w && addr == 4'd6) m_reload[31:0] = wr_data;
        if (w && addr == 4'd7) m_reload[63:32] = wr_data;
        if (w && addr == 4'd0) begin
            m_run = wr_data[0]; m_up = wr_data[1]; m_ar = wr_data[2];
            m_aen = wr_data[3]; m_sel = wr_data[4];
            m_div = int'(wr_data[16 +: DIV_W]);
        end else if (hit) begin
            m_aen = 0;
        end
        m_cnt = ncnt;
    endtask

    task automatic compare();
        logic [31:0] er;
        bit ei;
        er = model_read(addr);
        ei = m_raw && m_ien;
        n_cmp += 2;
        if (rd_data !== er) begin
            n_bad++;
            $display("FAIL %s: addr %0d read %h expected %h", cur_req, addr, rd_data, er);
        end
        if (irq !== ei) begin
            n_bad++;
            $display("FAIL %s: irq %b expected %b", cur_req, irq, ei);
        end
    endtask

    // Advance one clock: edge, reference update, compare away from the edge.
    task automatic cyc();
        @(posedge clk);
        if (!rst_n) model_reset(); else model_step();
        @(negedge clk);
        compare();
        src_tick[0] = ($urandom % 100) < rate0;
        src_tick[1] = ($urandom % 100) < rate1;
    endtask

    task automatic idle(input int n, input logic [3:0] a);
        addr = a;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Snapshot request (R6), then read the request bit and both words.
    task automatic snapshot();
        wr(4'd1, 32'd1);
        idle(1, 4'd1);
        idle(1, 4'd1);
        idle(1, 4'd2);
        idle(1, 4'd3);
    endtask

    function automatic logic [31:0] ctrl_word(input int dv, input bit sel, input bit aen,
                                              input bit ar, input bit up, input bit run,
                                              input bit drst);
        return (32'(dv) << 16) | (32'(drst) << 5) | (32'(sel) << 4) | (32'(aen) << 3)
               | (32'(ar) << 2) | (32'(up) << 1) | 32'(run);
    endfunction

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_bad++;
                $display("FAIL watchdog: run exceeded %0d cycles, expected completion", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        model_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3, 4'd0);
        rst_n = 1'b1;

        cur_req = "R1";
        for (int a = 0; a < 12; a++) idle(1, 4'(a));

        cur_req = "R2";
        rate0 = 70;
        wr(4'd0, ctrl_word(3, 0, 0, 0, 1, 1, 0));
        idle(40, 4'd0);
        snapshot();
        wr(4'd0, ctrl_word(0, 0, 0, 0, 1, 1, 0));
        idle(80, 4'd0);
        snapshot();
        wr(4'd0, ctrl_word(2, 0, 0, 0, 1, 1, 0));
        idle(20, 4'd0);
        snapshot();

        cur_req = "R3";
        wr(4'd0, ctrl_word(5, 0, 0, 0, 1, 1, 1));
        idle(7, 4'd0);
        wr(4'd0, ctrl_word(5, 0, 0, 0, 1, 1, 1));
        idle(13, 4'd0);
        snapshot();

        cur_req = "R9";
        wr(4'd6, 32'h0000_0001);
        wr(4'd7, 32'h0000_0000);
        wr(4'd8, 32'h1);
        snapshot();

        cur_req = "R4";
        rate0 = 100;
        wr(4'd0, ctrl_word(2, 0, 0, 0, 0, 1, 1));
        idle(8, 4'd0);
        snapshot();
        wr(4'd6, 32'hFFFF_FFFD);
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd8, 32'h1);
        wr(4'd0, ctrl_word(2, 0, 0, 0, 1, 1, 1));
        idle(10, 4'd0);
        snapshot();
        wr(4'd0, ctrl_word(2, 0, 0, 0, 1, 0, 0));
        idle(10, 4'd0);
        snapshot();

        cur_req = "R5";
        rate0 = 0; rate1 = 100;
        wr(4'd0, ctrl_word(2, 1, 0, 0, 1, 1, 1));
        idle(12, 4'd0);
        snapshot();
        rate0 = 100; rate1 = 0;
        idle(12, 4'd0);
        snapshot();

        cur_req = "R7";
        rate0 = 100; rate1 = 0;
        wr(4'd0, ctrl_word(2, 0, 0, 0, 1, 1, 1));
        snapshot();
        wr(4'd4, 32'(m_cnt + 64'd4));
        wr(4'd5, 32'((m_cnt + 64'd4) >> 32));
        wr(4'd0, ctrl_word(2, 0, 1, 0, 1, 1, 1));
        idle(10, 4'd10);
        idle(2, 4'd0);

        cur_req = "R10";
        idle(2, 4'd10);
        wr(4'd9, 32'h1);
        idle(2, 4'd9);
        wr(4'd11, 32'h1);
        idle(2, 4'd10);
        wr(4'd9, 32'h0);

        cur_req = "R8";
        wr(4'd6, 32'h0000_0100);
        wr(4'd7, 32'h0000_0002);
        wr(4'd8, 32'h1);
        wr(4'd4, 32'h0000_0103);
        wr(4'd5, 32'h0000_0002);
        wr(4'd9, 32'h1);
        wr(4'd0, ctrl_word(2, 0, 1, 1, 1, 1, 1));
        idle(12, 4'd10);
        snapshot();
        wr(4'd11, 32'h1);
        wr(4'd0, ctrl_word(2, 0, 1, 1, 1, 1, 0));
        idle(12, 4'd0);
        snapshot();

        cur_req = "R9";
        wr(4'd0, ctrl_word(0, 0, 1, 0, 0, 1, 0));
        wr(4'd6, 32'hDEAD_BEEF);
        wr(4'd7, 32'h0123_4567);
        wr(4'd8, 32'h1);
        snapshot();

        cur_req = "R6";
        rate0 = 60;
        wr(4'd0, ctrl_word(1, 0, 0, 0, 1, 1, 0));
        for (int k = 0; k < 5; k++) begin
            idle(k + 1, 4'd2);
            snapshot();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule